// File: doc/BRIEF.md
# Multi-Frame Power-Delay-Profile Averager

This block lowers the noise on a power delay profile by averaging several frames of it, one bin at a time. Samples arrive as a stream with a valid/ready handshake and a marker on the final sample of each frame. Bin k of every frame is added into a running sum kept for bin k in an internal sum bank. The bin position comes from a sample index that returns to zero after each frame marker. On the first frame of a run, the sum bank is loaded with the incoming values instead of being added to what it held before.

Software programs the frame count n and pulses `start`. Once the n-th frame marker has been accepted, the block stops taking input. It then drains the sum bank: a restoring divider divides each sum by n, and the truncated quotient is written into a result memory. When the last bin is written, `done` rises and stays high until the next `start`. Software reads the averages through a read port with one cycle of latency.

The controller has four named states. ST_IDLE is entered at reset and after the drain. ST_ACCUM takes input. ST_DIV_LOAD hands one sum to the divider. ST_DIV_WAIT waits for the quotient. The transitions are:
- start: any state goes to ST_ACCUM.
- last_frame_end: ST_ACCUM goes to ST_DIV_LOAD.
- div_issue: ST_DIV_LOAD goes to ST_DIV_WAIT.
- bin_written: ST_DIV_WAIT goes to ST_DIV_LOAD.
- drain_complete: ST_DIV_WAIT goes to ST_IDLE, taken when the bin just written is bin FRAME_LEN-1.

Top module: `pdp_frame_averager`

## Requirements
- R1: After reset, `in_ready` and `done` are low and `rd_data` is zero. Samples offered before the first `start` are not accepted.
- R2: In the cycle after a `start` pulse, `in_ready` is high and `done` is low. The frame count is captured at that pulse.
- R3: Each accepted sample at bin index k is added to the running sum for bin k. The bin index counts accepted samples and returns to 0 after a sample with `in_last` high.
- R4: The first frame of a run overwrites the sum bank, so no sum from an earlier run leaks into a new run.
- R5: From the edge that accepts the final `in_last` of the n-th frame until the next `start`, `in_ready` is low. Samples offered in that period do not change any result.
- R6: Result memory address k receives floor(sum_k / n), where n is the effective frame count.
- R7: A programmed count of 0 acts as 1. A count above NMAX acts as NMAX.
- R8: `done` rises in the cycle after the last bin is written and stays high until the next `start`. `done` and `in_ready` are never high together.
- R9: `rd_data` shows the result memory entry at `rd_addr` one cycle after the address is applied.
- R10: The sums cannot overflow. NMAX frames of full-scale input average back to full scale.
- R11: A `start` pulse during accumulation restarts the run. The frame count and the bin index return to zero, and only frames accepted after that pulse are averaged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a run and captures the frame count |
| cfg_frames | input | CNT_W | Number of frames to average |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W | Unsigned profile sample |
| in_last | input | 1 | Marks the final sample of a frame |
| in_ready | output | 1 | High while samples are accepted |
| done | output | 1 | High once all averages are written |
| rd_addr | input | IDX_W | Result memory read address |
| rd_data | output | DATA_W | Registered read data |

## Verification
`in_ready` follows the state register. It rises one edge after `start` and falls on the edge that accepts the n-th frame marker, so the bench samples it at the falling edge right after each of those edges. The drain takes ACC_W+2 cycles per bin, which is FRAME_LEN*(ACC_W+2) cycles in total. `done` rises on the edge that writes the last bin, so the bench polls it at falling edges, with a generous bound, before it reads any result. Each read applies the address at one falling edge and compares at the next, which respects the single register stage of the read port. One directed read also confirms that the old value is still present before that edge.

// File: rtl/pdp_avg_pkg.sv
package pdp_avg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_DIV_LOAD,
        ST_DIV_WAIT
    } avg_state_t;

endpackage

// File: rtl/pdp_restoring_divider.sv
module pdp_restoring_divider #(
    parameter int ACC_W = 19,
    parameter int DIV_W = 4,
    parameter int OUT_W = 16,
    localparam int STEP_W = $clog2(ACC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [ACC_W-1:0] dividend,
    input  logic [DIV_W-1:0] divisor,
    output logic             fin,
    output logic [OUT_W-1:0] quotient
);

    logic [DIV_W-1:0]  rem_q;
    logic [ACC_W-1:0]  quo_q;
    logic [STEP_W-1:0] steps_q;
    logic              fin_q;
    logic [DIV_W:0]    trial;
    logic              fits;

    // Shift the next dividend bit into the partial remainder
    assign trial = {rem_q, quo_q[ACC_W-1]};
    assign fits  = (trial >= {1'b0, divisor});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            steps_q <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                quo_q   <= dividend;
                rem_q   <= '0;
                steps_q <= STEP_W'(ACC_W);
            end else if (steps_q != '0) begin
                quo_q   <= {quo_q[ACC_W-2:0], fits};
                rem_q   <= fits ? DIV_W'(trial - {1'b0, divisor}) : trial[DIV_W-1:0];
                steps_q <= steps_q - 1'b1;
                fin_q   <= (steps_q == STEP_W'(1));
            end
        end
    end

    assign fin      = fin_q;
    assign quotient = quo_q[OUT_W-1:0];

endmodule

// File: rtl/pdp_sum_bank.sv
module pdp_sum_bank #(
    parameter int WIDTH = 19,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pdp_result_ram.sv
module pdp_result_ram #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pdp_frame_averager.sv
module pdp_frame_averager
    import pdp_avg_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FRAME_LEN = 32,
    parameter int NMAX      = 8,
    localparam int CNT_W = $clog2(NMAX + 1),
    localparam int IDX_W = $clog2(FRAME_LEN),
    localparam int ACC_W = DATA_W + $clog2(NMAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_frames,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              done,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [IDX_W-1:0] LAST_BIN = IDX_W'(FRAME_LEN - 1);

    avg_state_t state_q, state_d;

    logic [CNT_W-1:0]  n_q, n_eff, frame_q;
    logic [IDX_W-1:0]  idx_q, bin_q, sum_raddr;
    logic              done_q;
    logic              take, frame_end, final_frame;
    logic              div_go, div_fin, res_we;
    logic [ACC_W-1:0]  sum_rdata, sum_wdata;
    logic [DATA_W-1:0] div_quo;

    // Zero acts as one; anything above the storage limit is clamped
    always_comb begin
        if (cfg_frames == '0) begin
            n_eff = CNT_W'(1);
        end else if (cfg_frames > CNT_W'(NMAX)) begin
            n_eff = CNT_W'(NMAX);
        end else begin
            n_eff = cfg_frames;
        end
    end

    assign take        = in_valid && in_ready;
    assign frame_end   = take && in_last;
    assign final_frame = ((frame_q + CNT_W'(1)) == n_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_ACCUM;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ACCUM:    if (frame_end && final_frame) state_d = ST_DIV_LOAD;
                ST_DIV_LOAD: state_d = ST_DIV_WAIT;
                ST_DIV_WAIT: if (div_fin) state_d = (bin_q == LAST_BIN) ? ST_IDLE : ST_DIV_LOAD;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        in_ready = (state_q == ST_ACCUM);
        div_go   = (state_q == ST_DIV_LOAD);
        res_we   = (state_q == ST_DIV_WAIT) && div_fin;
    end

    // Counters, captured frame count and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q     <= CNT_W'(1);
            frame_q <= '0;
            idx_q   <= '0;
            bin_q   <= '0;
            done_q  <= 1'b0;
        end else if (start) begin
            n_q     <= n_eff;
            frame_q <= '0;
            idx_q   <= '0;
            bin_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            if (take) begin
                idx_q <= (in_last || idx_q == LAST_BIN) ? '0 : idx_q + 1'b1;
            end
            if (frame_end) begin
                frame_q <= frame_q + 1'b1;
            end
            if (res_we) begin
                bin_q <= (bin_q == LAST_BIN) ? '0 : bin_q + 1'b1;
                if (bin_q == LAST_BIN) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;

    assign sum_raddr = (state_q == ST_ACCUM) ? idx_q : bin_q;
    assign sum_wdata = (frame_q == '0) ? ACC_W'(in_data) : sum_rdata + ACC_W'(in_data);

    pdp_sum_bank #(
        .WIDTH (ACC_W),
        .DEPTH (FRAME_LEN)
    ) u_sums (
        .clk   (clk),
        .we    (take),
        .waddr (idx_q),
        .wdata (sum_wdata),
        .raddr (sum_raddr),
        .rdata (sum_rdata)
    );

    pdp_restoring_divider #(
        .ACC_W (ACC_W),
        .DIV_W (CNT_W),
        .OUT_W (DATA_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (sum_rdata),
        .divisor  (n_q),
        .fin      (div_fin),
        .quotient (div_quo)
    );

    pdp_result_ram #(
        .WIDTH (DATA_W),
        .DEPTH (FRAME_LEN)
    ) u_results (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (res_we),
        .waddr (bin_q),
        .wdata (div_quo),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/pdp_frame_averager_chk.sv
module pdp_frame_averager_chk #(
    parameter int NMAX  = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_ready,
    input logic             done,
    input logic             res_we,
    input logic [CNT_W-1:0] n_q
);

    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_ready && !done));

    assert_drain_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> !in_ready);

    assert_count_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q != '0) && (n_q <= CNT_W'(NMAX)));

    assert_ready_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && done));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(res_we));

endmodule

bind pdp_frame_averager pdp_frame_averager_chk #(
    .NMAX  (NMAX),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_ready (in_ready),
    .done     (done),
    .res_we   (res_we),
    .n_q      (n_q)
);

// File: tb/pdp_frame_averager_test.sv
module pdp_frame_averager_test;

    localparam int DATA_W    = 16;
    localparam int FRAME_LEN = 32;
    localparam int NMAX      = 8;
    localparam int CNT_W     = $clog2(NMAX + 1);
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam longint MAXV  = (64'd1 << DATA_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  cfg_frames = '0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              in_ready;
    logic              done;
    logic [IDX_W-1:0]  rd_addr = '0;
    logic [DATA_W-1:0] rd_data;

    int     n_checks = 0;
    int     n_fail = 0;
    longint exp_sum [FRAME_LEN];

    always #2 clk = ~clk;

    pdp_frame_averager #(
        .DATA_W    (DATA_W),
        .FRAME_LEN (FRAME_LEN),
        .NMAX      (NMAX)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_frames (cfg_frames),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .done       (done),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_n(input int cfg);
        if (cfg == 0) return 1;
        if (cfg > NMAX) return NMAX;
        return cfg;
    endfunction

    function automatic longint gen_sample(input int mode, input int f, input int k);
        case (mode)
            0:       return longint'($urandom_range(32'(MAXV), 0));
            1:       return (longint'(k) * 2047 + longint'(f) * 311) & MAXV;
            2:       return MAXV;
            default: return 0;
        endcase
    endfunction

    task automatic report_and_end();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // R2: start pulse opens the input; R8: start clears done
    task automatic pulse_start(input int cfg);
        @(negedge clk);
        cfg_frames = CNT_W'(cfg);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R2", "in_ready after start", longint'(in_ready), 1);
        check_eq("R2", "done cleared by start", longint'(done), 0);
        for (int k = 0; k < FRAME_LEN; k++) exp_sum[k] = 0;
    endtask

    // R3: one frame; bin k is the k-th accepted sample
    task automatic send_frame(input int mode, input int f, input bit counted);
        for (int k = 0; k < FRAME_LEN; k++) begin
            longint v;
            v = gen_sample(mode, f, k);
            in_valid = 1'b1;
            in_data  = DATA_W'(v);
            in_last  = (k == FRAME_LEN - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            if (counted) exp_sum[k] += v;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_done();
        int c;
        c = 0;
        while (!done && c < 5000) begin
            @(negedge clk);
            c++;
        end
        check_eq("R8", "done after drain", longint'(done), 1);
        check_eq("R8", "in_ready low while done", longint'(in_ready), 0);
    endtask

    task automatic check_results(input string req, input int n);
        for (int k = 0; k < FRAME_LEN; k++) begin
            @(negedge clk);
            rd_addr = IDX_W'(k);
            @(negedge clk);
            check_eq(req, $sformatf("average bin %0d", k), longint'(rd_data), exp_sum[k] / n);
        end
    endtask

    task automatic run_frames(input int cfg, input int mode, input string req);
        int n;
        n = eff_n(cfg);
        pulse_start(cfg);
        for (int f = 0; f < n; f++) begin
            send_frame((mode < 0) ? int'($urandom_range(3, 0)) : mode, f, 1'b1);
        end
        check_eq("R5", "in_ready low after final frame", longint'(in_ready), 0);
        wait_done();
        check_results(req, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report_and_end();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", "in_ready at reset", longint'(in_ready), 0);
        check_eq("R1", "done at reset", longint'(done), 0);
        check_eq("R1", "rd_data at reset", longint'(rd_data), 0);
        rst_n = 1'b1;
        // R1: samples before the first start are refused
        in_valid = 1'b1;
        in_data  = 16'h1234;
        repeat (4) begin
            @(negedge clk);
            check_eq("R1", "in_ready before start", longint'(in_ready), 0);
        end
        in_valid = 1'b0;

        // R3 R6: random frames, with junk offered during the drain (R5)
        pulse_start(4);
        for (int f = 0; f < 4; f++) send_frame(0, f, 1'b1);
        check_eq("R5", "in_ready low after final frame", longint'(in_ready), 0);
        in_valid = 1'b1;
        in_data  = DATA_W'(MAXV);
        in_last  = 1'b1;
        repeat (12) begin
            @(negedge clk);
            check_eq("R5", "in_ready low in drain", longint'(in_ready), 0);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        wait_done();
        check_results("R6", 4);

        // R9: read latency of one cycle
        @(negedge clk);
        rd_addr = IDX_W'(3);
        #1;
        check_eq("R9", "old data before edge", longint'(rd_data), exp_sum[FRAME_LEN-1] / 4);
        @(negedge clk);
        check_eq("R9", "new data after edge", longint'(rd_data), exp_sum[3] / 4);
        // R8: done holds while idle
        repeat (20) @(negedge clk);
        check_eq("R8", "done holds in idle", longint'(done), 1);

        // R4: new run overwrites stale sums
        run_frames(3, 1, "R4");
        // R7: zero count acts as one
        run_frames(0, 0, "R7");
        // R7: over-range count clamps to NMAX
        run_frames(15, -1, "R7");
        // R10: full scale over NMAX frames
        run_frames(NMAX, 2, "R10");

        // R11: restart mid-run; the earlier frames are discarded
        pulse_start(5);
        send_frame(2, 0, 1'b0);
        send_frame(0, 1, 1'b0);
        pulse_start(2);
        send_frame(0, 0, 1'b1);
        send_frame(1, 1, 1'b1);
        check_eq("R11", "in_ready low after restarted run", longint'(in_ready), 0);
        wait_done();
        check_results("R11", 2);

        report_and_end();
    end

endmodule